// File: doc/BRIEF.md
# AXI Handshake Balance Monitor

This block sits beside an AXI link and only listens. From the valid/ready pairs on the five channels it keeps five running balances: write addresses still waiting for a write response, write addresses still waiting for their last data beat, read addresses still waiting for their last read beat, read data beats still owed, and write data beats still owed. A response that shows up while its balance is already zero is a protocol fault. The block records that fault in a sticky status flag and pulses an interrupt line. It never drives any bus signal.

Each direction also has a cycle-based watchdog. It counts how long requests have been outstanding without any response making progress. When the count reaches a programmed threshold, the watchdog pulses its own interrupt and bumps a 48-bit event counter. A small word-indexed register port gives access to the enables, the thresholds, the status flags and all the counters.

Top module: `axi_balance_mon`

## Requirements
- R1: Balance AW−B rises on each AW handshake and falls on each B handshake. Balance AW−W rises on each AW handshake and falls on each W handshake that carries WLAST. Balance AR−R rises on each AR handshake and falls on each R handshake that carries RLAST. They read back at word indices 4, 5 and 6.
- R2: The register at word index 0 holds the enables in bits [4:0], in this order: AW−B, AW−W, AR−R, read beats, write beats. Every enable resets to 1. While an enable is 0, its balance holds its value and can raise no underflow.
- R3: The status register at word index 1 has two sticky flags. Bit 0 sets when a B handshake arrives while AW−B is zero. Bit 4 sets when an R handshake with RLAST arrives while AR−R is zero. Both flags reset to 0.
- R4: Each underflow drives its own interrupt, `irq_b_uf` or `irq_r_uf`, high for the single cycle after the offending handshake. The balance that underflowed stays at zero.
- R5: A request and its matching response in the same cycle leave the balance unchanged and flag no underflow.
- R6: The read-beat balance (index 7) grows by ARLEN+1 per AR handshake and shrinks by 1 per R handshake. The write-beat balance (index 8) does the same with AWLEN and W handshakes. A beat handshake at zero leaves the balance at zero and sets no flag.
- R7: Writing 1 to a status flag bit clears that flag. Writing 0 leaves it unchanged.
- R8: The read timeout threshold is at index 2 and the write threshold at index 3. Both are 32 bits wide and reset to 0. A value of 0 means 2^32 cycles. The read watchdog runs while AR−R is nonzero and restarts on every RLAST handshake. The write watchdog runs while AW−B is nonzero and restarts on every B handshake. It fires after the threshold count of such cycles.
- R9: A firing watchdog pulses `irq_rd_to` or `irq_wr_to` for one cycle and increments its 48-bit count. The read count reads back at indices 9 (low word) and 10 (high 16 bits). The write count reads back at indices 11 and 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| aw_valid | input | 1 | Observed AWVALID |
| aw_ready | input | 1 | Observed AWREADY |
| aw_len | input | 8 | Observed AWLEN |
| w_valid | input | 1 | Observed WVALID |
| w_ready | input | 1 | Observed WREADY |
| w_last | input | 1 | Observed WLAST |
| b_valid | input | 1 | Observed BVALID |
| b_ready | input | 1 | Observed BREADY |
| ar_valid | input | 1 | Observed ARVALID |
| ar_ready | input | 1 | Observed ARREADY |
| ar_len | input | 8 | Observed ARLEN |
| r_valid | input | 1 | Observed RVALID |
| r_ready | input | 1 | Observed RREADY |
| r_last | input | 1 | Observed RLAST |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_b_uf | output | 1 | Write-response underflow pulse |
| irq_r_uf | output | 1 | Read-response underflow pulse |
| irq_rd_to | output | 1 | Read timeout pulse |
| irq_wr_to | output | 1 | Write timeout pulse |

## Verification
The bench drives a request and its response in the same cycle. A design that applies the decrement before the increment would flag a false underflow there or drop a count. It sends lone responses into empty balances to confirm three things: the flag sets, the interrupt pulses once, and the balance stays at zero instead of wrapping to all ones. It also turns an enable off to confirm that a response into that frozen balance cannot raise a fault. The watchdogs are timed to the exact cycle, so an off-by-one in the threshold compare shows up. A zero threshold is checked to stay silent over a long wait rather than firing at once.

// File: rtl/axi_balance_mon.sv
`timescale 1ns/1ps
module axi_balance_mon #(
  parameter int BAL_W  = 16,
  parameter int LEN_W  = 8,
  parameter int THR_W  = 32,
  parameter int TCNT_W = 48
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              aw_valid,
  input  logic              aw_ready,
  input  logic [LEN_W-1:0]  aw_len,
  input  logic              w_valid,
  input  logic              w_ready,
  input  logic              w_last,
  input  logic              b_valid,
  input  logic              b_ready,
  input  logic              ar_valid,
  input  logic              ar_ready,
  input  logic [LEN_W-1:0]  ar_len,
  input  logic              r_valid,
  input  logic              r_ready,
  input  logic              r_last,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq_b_uf,
  output logic              irq_r_uf,
  output logic              irq_rd_to,
  output logic              irq_wr_to
);
  localparam int NBAL  = 5;
  localparam int SUM_W = BAL_W + 2;
  localparam logic [BAL_W:0] INC1 = 1;
  localparam logic [THR_W:0] TONE = 1;

  logic aw_hs, w_hs, b_hs, ar_hs, r_hs;
  assign aw_hs = aw_valid & aw_ready;
  assign w_hs  = w_valid  & w_ready;
  assign b_hs  = b_valid  & b_ready;
  assign ar_hs = ar_valid & ar_ready;
  assign r_hs  = r_valid  & r_ready;

  logic [NBAL-1:0]  en;
  logic [BAL_W-1:0] bal [NBAL];
  logic [BAL_W:0]   inc [NBAL];
  logic [NBAL-1:0]  dec;
  logic             st_b, st_r;
  logic [THR_W-1:0] thr [2];
  logic [TCNT_W-1:0] tcnt [2];
  logic [1:0]       busy, prog, to_irq;

  assign inc[0] = aw_hs ? INC1 : '0;
  assign inc[1] = aw_hs ? INC1 : '0;
  assign inc[2] = ar_hs ? INC1 : '0;
  assign inc[3] = ar_hs ? {{(BAL_W+1-LEN_W){1'b0}}, ar_len} + INC1 : '0;
  assign inc[4] = aw_hs ? {{(BAL_W+1-LEN_W){1'b0}}, aw_len} + INC1 : '0;
  assign dec    = {w_hs, r_hs, r_hs & r_last, w_hs & w_last, b_hs};

  for (genvar i = 0; i < NBAL; i++) begin : g_bal
    logic [SUM_W-1:0] sum, diff;
    logic [BAL_W-1:0] q;
    assign sum  = SUM_W'(bal[i]) + SUM_W'(inc[i]);
    assign diff = (dec[i] && sum != '0) ? sum - SUM_W'(1) : sum;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)     q <= '0;
      else if (en[i]) q <= (|diff[SUM_W-1:BAL_W]) ? '1 : diff[BAL_W-1:0];
    assign bal[i] = q;
  end

  logic b_uf, r_uf;
  assign b_uf = en[0] & b_hs & ~aw_hs & (bal[0] == '0);
  assign r_uf = en[2] & r_hs & r_last & ~ar_hs & (bal[2] == '0);

  logic ctl_we, st_we;
  assign ctl_we = reg_we && reg_addr == 4'd0;
  assign st_we  = reg_we && reg_addr == 4'd1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en       <= '1;
      thr[0]   <= '0;
      thr[1]   <= '0;
      st_b     <= 1'b0;
      st_r     <= 1'b0;
      irq_b_uf <= 1'b0;
      irq_r_uf <= 1'b0;
    end else begin
      if (ctl_we) en <= reg_wdata[NBAL-1:0];
      if (reg_we && reg_addr == 4'd2) thr[0] <= reg_wdata[THR_W-1:0];
      if (reg_we && reg_addr == 4'd3) thr[1] <= reg_wdata[THR_W-1:0];
      if (st_we && reg_wdata[0]) st_b <= 1'b0;
      if (st_we && reg_wdata[4]) st_r <= 1'b0;
      if (b_uf) st_b <= 1'b1;
      if (r_uf) st_r <= 1'b1;
      irq_b_uf <= b_uf;
      irq_r_uf <= r_uf;
    end

  assign busy = {bal[0] != '0, bal[2] != '0};
  assign prog = {b_hs, r_hs & r_last};

  for (genvar d = 0; d < 2; d++) begin : g_to
    logic [THR_W:0]    tmr, lim;
    logic [TCNT_W-1:0] cnt;
    logic              hit, fire_q;
    assign lim = {~|thr[d], thr[d]};
    assign hit = busy[d] & ~prog[d] & (tmr + TONE >= lim);
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        tmr    <= '0;
        cnt    <= '0;
        fire_q <= 1'b0;
      end else begin
        tmr    <= (!busy[d] || prog[d] || hit) ? '0 : tmr + TONE;
        if (hit) cnt <= cnt + TCNT_W'(1);
        fire_q <= hit;
      end
    assign tcnt[d]   = cnt;
    assign to_irq[d] = fire_q;
  end

  assign irq_rd_to = to_irq[0];
  assign irq_wr_to = to_irq[1];

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      4'd0:  reg_rdata = 32'(en);
      4'd1:  reg_rdata = {27'd0, st_r, 3'd0, st_b};
      4'd2:  reg_rdata = 32'(thr[0]);
      4'd3:  reg_rdata = 32'(thr[1]);
      4'd4:  reg_rdata = 32'(bal[0]);
      4'd5:  reg_rdata = 32'(bal[1]);
      4'd6:  reg_rdata = 32'(bal[2]);
      4'd7:  reg_rdata = 32'(bal[3]);
      4'd8:  reg_rdata = 32'(bal[4]);
      4'd9:  reg_rdata = tcnt[0][31:0];
      4'd10: reg_rdata = 32'(tcnt[0][TCNT_W-1:32]);
      4'd11: reg_rdata = tcnt[1][31:0];
      4'd12: reg_rdata = 32'(tcnt[1][TCNT_W-1:32]);
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/axi_balance_mon_chk.sv
`timescale 1ns/1ps
module axi_balance_mon_chk #(
  parameter int BAL_W  = 16,
  parameter int LEN_W  = 8,
  parameter int TCNT_W = 48
)(
  input logic              clk,
  input logic              rst_n,
  input logic              aw_hs,
  input logic              b_hs,
  input logic              ar_hs,
  input logic              r_hs,
  input logic              r_last,
  input logic [LEN_W-1:0]  ar_len,
  input logic [4:0]        en,
  input logic [BAL_W-1:0]  bal_awb,
  input logic [BAL_W-1:0]  bal_arr,
  input logic [BAL_W-1:0]  bal_rb,
  input logic              st_b,
  input logic              st_r,
  input logic              irq_b_uf,
  input logic              irq_r_uf,
  input logic              irq_rd_to,
  input logic [TCNT_W-1:0] rd_tcnt,
  input logic              reg_we,
  input logic [3:0]        reg_addr,
  input logic              wd0
);
  AST_B_UNDERFLOW_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (b_hs && !aw_hs && en[0] && bal_awb == '0) |=> (irq_b_uf && st_b)); // R3
  AST_R_UNDERFLOW_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (r_hs && r_last && !ar_hs && en[2] && bal_arr == '0) |=> (irq_r_uf && st_r)); // R3
  AST_UNDERFLOW_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (b_hs && !aw_hs && en[0] && bal_awb == '0) |=> bal_awb == '0); // R4
  AST_SAME_CYCLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (aw_hs && b_hs && en[0]) |=> bal_awb == $past(bal_awb)); // R5
  AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en[0] |=> bal_awb == $past(bal_awb)); // R2
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_b && !(reg_we && reg_addr == 4'd1 && wd0)) |=> st_b); // R7
  AST_RBEAT_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_hs && !r_hs && en[3] && bal_rb[BAL_W-1:BAL_W-2] == 2'b00)
    |=> bal_rb == $past(bal_rb) + BAL_W'($past(ar_len)) + BAL_W'(1)); // R6
  AST_TOUT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rd_to |-> rd_tcnt == $past(rd_tcnt) + TCNT_W'(1)); // R9
endmodule

bind axi_balance_mon axi_balance_mon_chk #(.BAL_W(BAL_W), .LEN_W(LEN_W), .TCNT_W(TCNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .aw_hs(aw_hs), .b_hs(b_hs), .ar_hs(ar_hs), .r_hs(r_hs),
  .r_last(r_last), .ar_len(ar_len), .en(en), .bal_awb(bal[0]), .bal_arr(bal[2]),
  .bal_rb(bal[3]), .st_b(st_b), .st_r(st_r), .irq_b_uf(irq_b_uf), .irq_r_uf(irq_r_uf),
  .irq_rd_to(irq_rd_to), .rd_tcnt(tcnt[0]), .reg_we(reg_we), .reg_addr(reg_addr),
  .wd0(reg_wdata[0])
);

// File: tb/sim_axi_balance_mon.sv
`timescale 1ns/1ps
module sim_axi_balance_mon;
  logic clk = 1'b0, rst_n = 1'b0;
  logic aw_valid = 0, aw_ready = 0, w_valid = 0, w_ready = 0, w_last = 0;
  logic b_valid = 0, b_ready = 0, ar_valid = 0, ar_ready = 0, r_valid = 0, r_ready = 0, r_last = 0;
  logic [7:0] aw_len = 0, ar_len = 0;
  logic reg_we = 0;
  logic [3:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic irq_b_uf, irq_r_uf, irq_rd_to, irq_wr_to;

  always #2 clk = ~clk;

  axi_balance_mon u0 (.*);

  typedef struct { bit is_irq; logic [31:0] exp; string req; } item_t;
  item_t q[$];
  event done;
  int compared = 0, mismatched = 0;
  bit ended = 0;

  initial forever begin
    item_t it;
    logic [31:0] act;
    wait (q.size() > 0);
    #0.1;
    it  = q.pop_front();
    act = it.is_irq ? {28'd0, irq_wr_to, irq_rd_to, irq_r_uf, irq_b_uf} : reg_rdata;
    compared++;
    if (act !== it.exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", it.req, act, it.exp);
    end
    ->done;
  end

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_reg(input logic [3:0] a, input logic [31:0] e, input string r);
    reg_addr = a;
    q.push_back('{1'b0, e, r});
    @done;
  endtask

  task automatic expect_irq(input logic [3:0] e, input string r);
    q.push_back('{1'b1, {28'd0, e}, r});
    @done;
  endtask

  task automatic wreg(input logic [3:0] a, input logic [31:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    cyc();
    reg_we = 0;
  endtask

  task automatic hs(input bit aw, input bit w, input bit wl, input bit b,
                    input bit ar, input bit r, input bit rl, input int awl = 0, input int arl = 0);
    aw_valid = aw; aw_ready = aw; aw_len = 8'(awl);
    w_valid = w; w_ready = w; w_last = wl;
    b_valid = b; b_ready = b;
    ar_valid = ar; ar_ready = ar; ar_len = 8'(arl);
    r_valid = r; r_ready = r; r_last = rl;
    cyc();
    {aw_valid, aw_ready, w_valid, w_ready, w_last, b_valid, b_ready} = '0;
    {ar_valid, ar_ready, r_valid, r_ready, r_last} = '0;
  endtask

  task automatic summary();
    ended = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      mismatched++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      summary();
    end
  end

  initial begin
    cyc(3);
    rst_n = 1;
    cyc();
    // reset state
    expect_reg(0, 32'h1F, "R2 enables reset to ones");
    expect_reg(1, 0, "R3 status reset");
    expect_reg(4, 0, "R1 AW-B reset");
    expect_reg(6, 0, "R1 AR-R reset");
    expect_irq(0, "R4 no interrupt at reset");
    cyc();
    expect_reg(2, 0, "R8 read threshold reset");
    expect_reg(8, 0, "R6 write beats reset");
    expect_reg(9, 0, "R9 read timeout count reset");
    expect_reg(11, 0, "R9 write timeout count reset");
    cyc();
    // write burst of 4 beats
    hs(1,0,0,0,0,0,0, 3);
    expect_reg(4, 1, "R1 AW-B after AW");
    expect_reg(5, 1, "R1 AW-W after AW");
    expect_reg(8, 4, "R6 write beats after AWLEN=3");
    hs(0,1,0,0,0,0,0); hs(0,1,0,0,0,0,0); hs(0,1,0,0,0,0,0);
    expect_reg(8, 1, "R6 write beats after 3 W");
    expect_reg(5, 1, "R1 AW-W holds without WLAST");
    hs(0,1,1,0,0,0,0);
    expect_reg(8, 0, "R6 write beats drained");
    expect_reg(5, 0, "R1 AW-W after WLAST");
    hs(0,0,0,1,0,0,0);
    expect_reg(4, 0, "R1 AW-B after B");
    expect_irq(0, "R4 no underflow on balanced B");
    // same-cycle AW and B with AW-B at zero
    hs(1,0,0,1,0,0,0, 0);
    expect_reg(4, 0, "R5 AW-B unchanged on same-cycle AW and B");
    expect_reg(1, 0, "R5 no underflow flag on same-cycle pair");
    expect_irq(0, "R5 no interrupt on same-cycle pair");
    hs(0,1,1,0,0,0,0);
    expect_reg(5, 0, "R1 AW-W back to zero");
    // lone B into empty balance
    hs(0,0,0,1,0,0,0);
    expect_irq(4'b0001, "R4 write underflow pulse");
    expect_reg(1, 32'h01, "R3 write underflow flag at bit 0");
    expect_reg(4, 0, "R4 AW-B stays zero");
    cyc();
    expect_irq(0, "R4 pulse lasts one cycle");
    expect_reg(1, 32'h01, "R3 flag is sticky");
    // lone RLAST into empty balance
    hs(0,0,0,0,0,1,1);
    expect_irq(4'b0010, "R4 read underflow pulse");
    expect_reg(1, 32'h11, "R3 read underflow flag at bit 4");
    expect_reg(6, 0, "R4 AR-R stays zero");
    expect_reg(7, 0, "R6 read beats stay zero");
    // write-one-to-clear
    wreg(1, 32'h01);
    expect_reg(1, 32'h10, "R7 bit 0 cleared, bit 4 kept");
    wreg(1, 32'h00);
    expect_reg(1, 32'h10, "R7 writing zero keeps flag");
    wreg(1, 32'h10);
    expect_reg(1, 0, "R7 bit 4 cleared");
    // AW-B disabled
    wreg(0, 32'h1E);
    expect_reg(0, 32'h1E, "R2 enable readback");
    hs(1,0,0,0,0,0,0, 0);
    expect_reg(4, 0, "R2 disabled AW-B holds");
    expect_reg(5, 1, "R2 enabled AW-W still counts");
    hs(0,0,0,1,0,0,0);
    expect_irq(0, "R2 no underflow from disabled balance");
    expect_reg(1, 0, "R2 no flag from disabled balance");
    wreg(0, 32'h1F);
    hs(0,1,1,0,0,0,0);
    expect_reg(5, 0, "R1 AW-W drained");
    expect_reg(8, 0, "R6 write beats drained");
    // read beats with overlap
    hs(0,0,0,0,1,0,0, 0, 1);
    expect_reg(6, 1, "R1 AR-R after AR");
    expect_reg(7, 2, "R6 read beats after ARLEN=1");
    hs(0,0,0,0,1,1,0, 0, 2);
    expect_reg(7, 4, "R6 AR with ARLEN=2 and R beat together");
    expect_reg(6, 2, "R1 AR-R after second AR");
    hs(0,0,0,0,0,1,0); hs(0,0,0,0,0,1,1);
    expect_reg(7, 2, "R6 read beats after two R");
    expect_reg(6, 1, "R1 AR-R after RLAST");
    hs(0,0,0,0,0,1,0); hs(0,0,0,0,0,1,1);
    expect_reg(7, 0, "R6 read beats drained");
    expect_reg(6, 0, "R1 AR-R drained");
    hs(0,0,0,0,0,1,0);
    expect_reg(7, 0, "R6 beat at zero stays zero");
    expect_reg(1, 0, "R6 beat at zero sets no flag");
    // read timeout, threshold 5
    wreg(2, 5);
    expect_reg(2, 5, "R8 read threshold readback");
    hs(0,0,0,0,1,0,0, 0, 0);
    cyc(4);
    expect_irq(0, "R8 no read timeout before threshold");
    cyc();
    expect_irq(4'b0100, "R9 read timeout pulse at threshold");
    expect_reg(9, 1, "R9 read timeout count");
    expect_reg(10, 0, "R9 read timeout count high");
    hs(0,0,0,0,0,1,1);
    expect_irq(0, "R9 read timeout pulse ended");
    expect_reg(6, 0, "R1 AR-R drained after timeout");
    // write threshold zero means 2^32
    hs(1,0,0,0,0,0,0, 0);
    cyc(40);
    expect_irq(0, "R8 zero threshold does not fire");
    expect_reg(11, 0, "R8 zero threshold count stays zero");
    hs(0,0,0,1,0,0,0);
    hs(0,1,1,0,0,0,0);
    wreg(3, 3);
    hs(1,0,0,0,0,0,0, 0);
    cyc(2);
    expect_irq(0, "R8 no write timeout before threshold");
    cyc();
    expect_irq(4'b1000, "R9 write timeout pulse at threshold");
    expect_reg(11, 1, "R9 write timeout count");
    hs(0,0,0,1,0,0,0);
    hs(0,1,1,0,0,0,0);
    expect_reg(4, 0, "R1 AW-B drained at end");
    cyc(2);
    summary();
  end
endmodule